// File: doc/BRIEF.md
# Dual-Bus DDR ADC Sample Packer

This block receives the sample stream of one high-speed analog-to-digital converter that launches its data source-synchronously on double-data-rate buses, clocked by a bit clock supplied by the converter. In dual-bus mode, two buses each carry alternate samples, and the bit clock runs at one quarter of the sample rate. Both buses are captured on both clock edges, so four samples arrive per bit-clock period. The block puts these four samples back into time order and emits them as one wide word. A capture memory that runs no faster than one write per bit-clock cycle can store that word directly.

In single-bus mode, bus A alone carries every sample at twice the dual-bus clock rate. The two samples of one period are held and combined with the two samples of the next period. The result is the same four-sample word, produced on every second cycle. A valid strobe marks each completed word. A synchronous reset, or any change of the mode input, restarts the packing phase. Valid then stays low until a fresh word has been assembled. The block never needs to know which converter sample a capture began on. It only guarantees that the samples of one converter leave in the order they arrived.

Top module: `adc_ddr_packer`

## Requirements
- R1: With `mode_single_i` = 0 (dual-bus), one bit-clock period yields the word with A-rise in bits [W-1:0], B-rise in [2W-1:W], A-fall in [3W-1:2W] and B-fall in [4W-1:3W], where W = SAMPLE_W. A rise sample is the bus value at a rising edge. A fall sample is the bus value at the falling edge that follows it.
- R2: In dual-bus mode, once running, `word_valid_o` is high on every cycle, and every captured period produces exactly one word.
- R3: The word of a period whose rising-edge capture is at edge n is visible with valid high right after edge n+1. This holds in dual-bus mode, and in single-bus mode for the second period of a pair.
- R4: With `mode_single_i` = 1 (single-bus), two consecutive periods k and k+1 on bus A form one word: A-rise(k) in [W-1:0], A-fall(k) in [2W-1:W], A-rise(k+1) in [3W-1:2W] and A-fall(k+1) in [4W-1:3W]. Valid is high on every second cycle and never on two cycles in a row.
- R5: In single-bus mode, bus B has no effect on `word_o` or `word_valid_o`.
- R6: When `rst` is high at a rising edge, valid is low right after that edge, and the pairing phase is cleared. The first period whose rising edge sees `rst` low is the first one that is packed, and in single-bus mode it opens a new pair.
- R7: A change of `mode_single_i` discards the period captured at the first rising edge that sees the new value. It also drops any half-built single-bus pair. Packing then restarts in the new mode with the next period, as after reset.
- R8: `word_o` keeps its last value on cycles where `word_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the converter; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| mode_single_i | input | 1 | 0 = dual-bus, 1 = single-bus (bus A only) |
| bus_a_i | input | SAMPLE_W | DDR data bus A |
| bus_b_i | input | SAMPLE_W | DDR data bus B (unused in single-bus mode) |
| word_o | output | 4*SAMPLE_W | Four time-ordered samples, earliest in the lowest bits |
| word_valid_o | output | 1 | High for one cycle per completed word |

## Verification
Each word is due exactly one rising edge after the rising-edge capture of its last period, meaning edge n+1 for a period captured at edge n. Words of the first period of a single-bus pair, and of any period discarded by reset or a mode change, are never due. The driver records the bench cycle count at every rising capture and pushes the expected word with its due cycle. The monitor samples on the falling edge, pops each word and compares both its content and the cycle it appeared on. On cycles without a word, the monitor checks that the output held its previous value.

// File: rtl/adc_pk_pkg.sv
package adc_pk_pkg;
  localparam int NUM_BUS          = 2;
  localparam int SAMPLES_PER_WORD = 4;

  typedef enum logic {
    PK_DUAL   = 1'b0,
    PK_SINGLE = 1'b1
  } pk_mode_e;
endpackage

// File: rtl/adc_pk_capture.sv
// Captures one DDR bus: rising-edge sample and falling-edge sample.
// The falling-edge register is read only by rising-edge logic downstream,
// which re-times it into the rising-edge domain.
module adc_pk_capture #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] rise_q,
  output logic [SAMPLE_W-1:0] fall_q
);
  always_ff @(posedge clk) begin
    rise_q <= din;
  end

  always_ff @(negedge clk) begin
    fall_q <= din;
  end
endmodule

// File: rtl/adc_pk_ctrl.sv
// Tracks the active mode and marks captured periods as usable.
// A period is unusable if reset or a mode change is seen at its rising edge.
module adc_pk_ctrl
  import adc_pk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_single_i,
  output logic single_o,
  output logic stage_vld_o
);
  pk_mode_e mode_q;
  logic     mode_same;

  assign mode_same = (pk_mode_e'(mode_single_i) == mode_q);
  assign single_o  = (mode_q == PK_SINGLE);

  always_ff @(posedge clk) begin
    mode_q <= pk_mode_e'(mode_single_i);
    if (rst) begin
      stage_vld_o <= 1'b0;
    end else begin
      stage_vld_o <= mode_same;
    end
  end
endmodule

// File: rtl/adc_pk_packer.sv
// Orders the captured samples into a four-sample word. In single-bus mode
// the first period of a pair is held and combined with the second.
module adc_pk_packer
  import adc_pk_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int WORD_W  = SAMPLES_PER_WORD * SAMPLE_W,
  localparam int HALF_W  = WORD_W / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stage_vld,
  input  logic                single,
  input  logic [SAMPLE_W-1:0] rise_a,
  input  logic [SAMPLE_W-1:0] rise_b,
  input  logic [SAMPLE_W-1:0] fall_a,
  input  logic [SAMPLE_W-1:0] fall_b,
  output logic [WORD_W-1:0]   word_o,
  output logic                valid_o
);
  logic              phase_q;
  logic [HALF_W-1:0] hold_q;
  logic [HALF_W-1:0] pair_a;

  // two samples of bus A in time order, earliest lowest
  assign pair_a = {fall_a, rise_a};

  always_ff @(posedge clk) begin
    if (rst || !stage_vld) begin
      phase_q <= 1'b0;
      valid_o <= 1'b0;
    end else if (!single) begin
      word_o  <= {fall_b, fall_a, rise_b, rise_a};
      valid_o <= 1'b1;
      phase_q <= 1'b0;
    end else if (!phase_q) begin
      hold_q  <= pair_a;
      valid_o <= 1'b0;
      phase_q <= 1'b1;
    end else begin
      word_o  <= {pair_a, hold_q};
      valid_o <= 1'b1;
      phase_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_ddr_packer.sv
module adc_ddr_packer
  import adc_pk_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int WORD_W  = SAMPLES_PER_WORD * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_single_i,
  input  logic [SAMPLE_W-1:0] bus_a_i,
  input  logic [SAMPLE_W-1:0] bus_b_i,
  output logic [WORD_W-1:0]   word_o,
  output logic                word_valid_o
);
  logic [SAMPLE_W-1:0] bus_in [NUM_BUS];
  logic [SAMPLE_W-1:0] rise_s [NUM_BUS];
  logic [SAMPLE_W-1:0] fall_s [NUM_BUS];
  logic                mode_lat;
  logic                stage_vld;
  logic [SAMPLE_W-1:0] rise_a;

  assign bus_in[0] = bus_a_i;
  assign bus_in[1] = bus_b_i;
  assign rise_a    = rise_s[0];

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_cap
    adc_pk_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
      .clk    (clk),
      .din    (bus_in[g]),
      .rise_q (rise_s[g]),
      .fall_q (fall_s[g])
    );
  end

  adc_pk_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .mode_single_i (mode_single_i),
    .single_o      (mode_lat),
    .stage_vld_o   (stage_vld)
  );

  adc_pk_packer #(.SAMPLE_W(SAMPLE_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .stage_vld (stage_vld),
    .single    (mode_lat),
    .rise_a    (rise_s[0]),
    .rise_b    (rise_s[1]),
    .fall_a    (fall_s[0]),
    .fall_b    (fall_s[1]),
    .word_o    (word_o),
    .valid_o   (word_valid_o)
  );
endmodule

// File: rtl/adc_ddr_packer_chk.sv
module adc_ddr_packer_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  mode_lat,
  input logic                  stage_vld,
  input logic [SAMPLE_W-1:0]   rise_a,
  input logic [4*SAMPLE_W-1:0] word_o,
  input logic                  word_valid_o
);
  // R6: no word right after a reset edge
  p_rst_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !word_valid_o);

  // R2: a usable dual-bus period always yields a word next cycle
  p_dual_every_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (stage_vld && !mode_lat) |=> word_valid_o);

  // R1: lowest lane of a dual-bus word is the bus A rising capture
  p_dual_lane0_r1: assert property (@(posedge clk) disable iff (rst)
    (stage_vld && !mode_lat) |=> (word_o[SAMPLE_W-1:0] == $past(rise_a)));

  // R4: single-bus words never on two cycles in a row
  p_single_alternate_r4: assert property (@(posedge clk) disable iff (rst)
    (word_valid_o && mode_lat) |=> !word_valid_o);

  // R7: a word only follows a usable period
  p_valid_needs_stage_r7: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> $past(stage_vld));
endmodule

bind adc_ddr_packer adc_ddr_packer_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_lat     (mode_lat),
  .stage_vld    (stage_vld),
  .rise_a       (rise_a),
  .word_o       (word_o),
  .word_valid_o (word_valid_o)
);

// File: tb/adc_ddr_packer_tb.sv
`timescale 1ns/1ps
module adc_ddr_packer_tb;
  localparam int W  = 12;
  localparam int WW = 4 * W;

  typedef struct {
    logic [WW-1:0] w;
    int            due;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_single = 1'b0;
  logic [W-1:0]  bus_a = '0;
  logic [W-1:0]  bus_b = '0;
  logic [WW-1:0] word_o;
  logic          word_valid_o;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  int   sidx = 0;
  exp_t exp_q[$];
  logic [WW-1:0] last_w;
  bit   have_last = 1'b0;

  adc_ddr_packer #(.SAMPLE_W(W)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .mode_single_i (mode_single),
    .bus_a_i       (bus_a),
    .bus_b_i       (bus_b),
    .word_o        (word_o),
    .word_valid_o  (word_valid_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] smp(input int k);
    return W'((k * 419 + 77) ^ (k >> 3));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                     input logic [WW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // one bit-clock period: rising sample then falling sample
  task automatic period(input logic [W-1:0] ar, input logic [W-1:0] br,
                        input logic [W-1:0] af, input logic [W-1:0] bf,
                        output int rcyc);
    bus_a = ar; bus_b = br;
    @(posedge clk); #1;
    rcyc  = cyc;
    bus_a = af; bus_b = bf;
    @(negedge clk); #1;
  endtask

  task automatic dual_word(input bit push, input string req);
    int c;
    exp_t e;
    period(smp(sidx), smp(sidx+1), smp(sidx+2), smp(sidx+3), c);
    if (push) begin
      e.w   = {smp(sidx+3), smp(sidx+2), smp(sidx+1), smp(sidx)};
      e.due = c + 1;
      e.req = req;
      exp_q.push_back(e);
    end
    sidx += 4;
  endtask

  // single-bus period on bus A; bus B carries unrelated values (R5)
  task automatic single_period(output int c);
    period(smp(sidx), W'(cyc * 7 + 3), smp(sidx+1), W'(cyc * 13 + 9), c);
    sidx += 2;
  endtask

  task automatic single_pair(input string req);
    int c1, c2;
    exp_t e;
    int b;
    b = sidx;
    single_period(c1);
    single_period(c2);
    e.w   = {smp(b+3), smp(b+2), smp(b+1), smp(b)};
    e.due = c2 + 1;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor, away from the rising edge
  always @(negedge clk) begin
    if (word_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected word", word_o, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(word_o == e.w, e.req, word_o, e.w);
        chk(cyc == e.due, "R3 latency", WW'(cyc), WW'(e.due));
      end
      last_w    = word_o;
      have_last = 1'b1;
    end else if (have_last) begin
      chk(word_o == last_w, "R8 hold", word_o, last_w);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    @(negedge clk); #1;
    // R6: reset state
    for (int i = 0; i < 3; i++) begin
      dual_word(1'b0, "");
      chk(word_valid_o == 1'b0, "R6 valid in reset", WW'(word_valid_o), '0);
    end
    rst = 1'b0;

    // R1 R2 R3: dual-bus streaming
    for (int i = 0; i < 16; i++) dual_word(1'b1, "R1 dual order");

    // R7: switch to single, first period discarded
    mode_single = 1'b1;
    dual_word(1'b0, "");
    for (int i = 0; i < 6; i++) single_pair("R4/R5 single pair");

    // R7: half pair, then switch back to dual
    single_period(c);
    mode_single = 1'b0;
    dual_word(1'b0, "");
    chk(word_valid_o == 1'b0, "R7 no word on switch", WW'(word_valid_o), '0);
    for (int i = 0; i < 8; i++) dual_word(1'b1, "R7 dual after switch");

    // R6: reset in single mode with a half pair held
    mode_single = 1'b1;
    dual_word(1'b0, "");
    for (int i = 0; i < 2; i++) single_pair("R4 single pair");
    single_period(c);
    single_period(c);
    rst = 1'b1;
    single_period(c);
    chk(word_valid_o == 1'b0, "R6 valid after reset edge", WW'(word_valid_o), '0);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) single_pair("R6 pairing restarts");

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all words emitted", WW'(exp_q.size()), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule